// File: doc/BRIEF.md
# Three-Address Memory-to-Memory Sequencer

This block executes a stream of byte-wide arithmetic and logic instructions held in a byte-addressed synchronous memory. Each instruction names two source locations and one destination location by full memory address. The block fetches the instruction, reads both sources, combines them and stores the result. It then moves on to the next instruction, whose location comes from an internal program counter rather than from the instruction.

An instruction occupies ten consecutive bytes. The first byte is the operation code. It is followed by the first source address, the second source address and the destination address, each three bytes long with the most significant byte at the lowest location. The block owns a single memory port that carries at most one access per cycle, and read data returns one cycle after the request. A complete arithmetic instruction therefore takes thirteen cycles and thirteen accesses. A running access counter lets a system observe that cost directly.

After reset the sequencer is idle with its program counter at zero. A single-cycle start pulse sets it running. It stays busy until it fetches a stop code or an unknown code, and it then parks in a halted state until the next reset.

Top module: `tri_addr_exec`

## Requirements
- R1: During and immediately after reset, busy, halted, err, mem_req, pc and acc_count are all zero.
- R2: A start pulse while idle makes busy high on the next cycle, together with a read request at address pc.
- R3: The fetch reads addresses pc through pc+9 in ascending order, one per cycle. Byte pc is the opcode, bytes pc+1..pc+3 are source address A, bytes pc+4..pc+6 are source address B and bytes pc+7..pc+9 are the destination. Each address field has its most significant byte first.
- R4: The value written is A op B, truncated to 8 bits. The opcode values are 0x00 add, 0x01 subtract (A minus B, wrapping), 0x02 bitwise and, 0x03 bitwise or and 0x04 bitwise xor.
- R5: Right after the fetch, the block reads address A, then reads address B, then performs exactly one write to the destination, on three consecutive cycles.
- R6: After each completed arithmetic instruction, pc increases by exactly 10, and pc changes at no other time.
- R7: acc_count increases by one for every cycle with mem_req high, reads and writes alike. An arithmetic instruction therefore costs 13 accesses.
- R8: Opcode 0xFF stops the block after its single opcode read. busy falls, halted rises, err stays low, pc keeps the address of the stop code, and no further requests are made.
- R9: Any opcode other than 0x00 to 0x04 and 0xFF stops the block in the same way as R8, but also sets err.
- R10: start has no effect while the block is busy or halted.
- R11: A result written by one instruction is seen by later instructions that read that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins execution from idle |
| mem_req | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | High for a write, low for a read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | BYTE_W | Data to store on a write |
| mem_rdata | input | BYTE_W | Read data, valid the cycle after a read request |
| busy | output | 1 | Executing instructions |
| halted | output | 1 | Stopped on a stop or unknown opcode |
| err | output | 1 | The stop was caused by an unknown opcode |
| pc | output | ADDR_W | Address of the current instruction |
| acc_count | output | CNT_W | Count of memory accesses since reset |

## Verification
The hardest case to reach is a start pulse that arrives in the middle of an instruction. That pulse must leave the tightly timed sequence of thirteen accesses unchanged. The bench raises start while the second instruction is still fetching, and its scoreboard compares every request against the predicted address, direction and data, so any disturbance is caught. The chained instruction, which reads two results written earlier and wraps on addition, shows that a write takes effect before later reads. A second program that ends on an unknown opcode reaches the error stop.

// File: rtl/tae_pkg.sv
package tae_pkg;

   localparam logic [7:0] OPC_ADD  = 8'h00;
   localparam logic [7:0] OPC_SUB  = 8'h01;
   localparam logic [7:0] OPC_AND  = 8'h02;
   localparam logic [7:0] OPC_OR   = 8'h03;
   localparam logic [7:0] OPC_XOR  = 8'h04;
   localparam logic [7:0] OPC_STOP = 8'hFF;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_SRC_A,
      ST_SRC_B,
      ST_STORE,
      ST_STOP
   } tae_state_e;

   function automatic logic opc_known(input logic [7:0] o);
      return (o <= OPC_XOR) || (o == OPC_STOP);
   endfunction

endpackage

// File: rtl/tae_alu.sv
module tae_alu #(
   parameter int W = 8
) (
   input  logic [7:0]   opc,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   import tae_pkg::*;

   always_comb begin
      case (opc)
         OPC_ADD: y = a + b;
         OPC_SUB: y = a - b;
         OPC_AND: y = a & b;
         OPC_OR:  y = a | b;
         OPC_XOR: y = a ^ b;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/tae_field_asm.sv
module tae_field_asm #(
   parameter int ADDR_W    = 24,
   parameter int BYTE_W    = 8,
   parameter int N_FIELDS  = 3,
   parameter bit MSB_FIRST = 1'b1,
   localparam int AB       = ADDR_W / BYTE_W,
   localparam int IW       = $clog2(N_FIELDS * AB)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             load,
   input  logic [IW-1:0]                    idx,
   input  logic [BYTE_W-1:0]                din,
   output logic [N_FIELDS-1:0][ADDR_W-1:0]  fields
);

   // Lane of byte b inside its field, chosen by storage order.
   function automatic int lane(input int b);
      return MSB_FIRST ? (AB - 1 - b) : b;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fields <= '0;
      end else if (load) begin
         for (int f = 0; f < N_FIELDS; f++) begin
            for (int b = 0; b < AB; b++) begin
               if (idx == IW'(f * AB + b))
                  fields[f][lane(b)*BYTE_W +: BYTE_W] <= din;
            end
         end
      end
   end

endmodule

// File: rtl/tae_acc_cnt.sv
module tae_acc_cnt #(
   parameter int W        = 32,
   parameter bit SATURATE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)              cnt <= '0;
            else if (inc && ~&cnt)   cnt <= cnt + W'(1);
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)   cnt <= '0;
            else if (inc) cnt <= cnt + W'(1);
         end

         a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            inc |=> cnt == $past(cnt) + W'(1));
         a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !inc |=> $stable(cnt));
      end
   endgenerate

endmodule

// File: rtl/tae_seq.sv
module tae_seq #(
   parameter int ADDR_W   = 24,
   parameter int BYTE_W   = 8,
   localparam int AB      = ADDR_W / BYTE_W,
   localparam int NB      = 1 + 3 * AB,
   localparam int SW      = $clog2(NB),
   localparam int IW      = $clog2(3 * AB)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [BYTE_W-1:0]        mem_rdata,
   input  logic [2:0][ADDR_W-1:0]   fields,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic                     fa_load,
   output logic [IW-1:0]            fa_idx,
   output logic [7:0]               opc_q,
   output logic [BYTE_W-1:0]        op_a_q,
   output logic                     busy,
   output logic                     halted,
   output logic                     err,
   output logic [ADDR_W-1:0]        pc
);
   import tae_pkg::*;

   tae_state_e        state_q;
   logic [SW-1:0]     step_q;
   logic [ADDR_W-1:0] pc_q;
   logic              err_q;
   logic              cap_vld_q;
   logic [SW-1:0]     cap_idx_q;
   logic              opc_arrive;
   logic              stop_now;

   always_comb begin
      opc_arrive = cap_vld_q && (cap_idx_q == '0);
      stop_now   = opc_arrive &&
                   ((mem_rdata[7:0] == OPC_STOP) || !opc_known(mem_rdata[7:0]));
      fa_load    = cap_vld_q && (cap_idx_q != '0);
      fa_idx     = IW'(cap_idx_q - SW'(1));
      mem_req    = 1'b0;
      mem_we     = 1'b0;
      mem_addr   = pc_q;
      case (state_q)
         ST_FETCH: begin
            mem_req  = !stop_now;
            mem_addr = pc_q + ADDR_W'(step_q);
         end
         ST_SRC_A: begin
            mem_req  = 1'b1;
            mem_addr = fields[0];
         end
         ST_SRC_B: begin
            mem_req  = 1'b1;
            mem_addr = fields[1];
         end
         ST_STORE: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = fields[2];
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         step_q    <= '0;
         pc_q      <= '0;
         opc_q     <= '0;
         op_a_q    <= '0;
         err_q     <= 1'b0;
         cap_vld_q <= 1'b0;
         cap_idx_q <= '0;
      end else begin
         cap_vld_q <= (state_q == ST_FETCH) && mem_req;
         cap_idx_q <= step_q;
         if (opc_arrive) opc_q <= mem_rdata[7:0];
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_FETCH;
                  step_q  <= '0;
               end
            end
            ST_FETCH: begin
               if (stop_now) begin
                  state_q <= ST_STOP;
                  err_q   <= (mem_rdata[7:0] != OPC_STOP);
               end else if (step_q == SW'(NB - 1)) begin
                  state_q <= ST_SRC_A;
               end else begin
                  step_q <= step_q + SW'(1);
               end
            end
            ST_SRC_A: state_q <= ST_SRC_B;
            ST_SRC_B: begin
               op_a_q  <= mem_rdata;
               state_q <= ST_STORE;
            end
            ST_STORE: begin
               pc_q    <= pc_q + ADDR_W'(NB);
               step_q  <= '0;
               state_q <= ST_FETCH;
            end
            ST_STOP: state_q <= ST_STOP;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (state_q != ST_IDLE) && (state_q != ST_STOP);
   assign halted = (state_q == ST_STOP);
   assign err    = err_q;
   assign pc     = pc_q;

   a_r2_start_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !halted && start) |=> (busy && mem_req && !mem_we && mem_addr == pc));
   a_r5_store_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(mem_req && !mem_we));
   a_r6_pc_stride: assert property (@(posedge clk) disable iff (!rst_n)
      (pc != $past(pc)) |-> (pc == $past(pc) + ADDR_W'(NB)));
   a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_req);
   a_r8_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);
   a_r9_err_means_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (halted && !busy));

endmodule

// File: rtl/tri_addr_exec.sv
module tri_addr_exec #(
   parameter int ADDR_W         = 24,
   parameter int BYTE_W         = 8,
   parameter int CNT_W          = 32,
   parameter bit ADDR_MSB_FIRST = 1'b1,
   parameter bit CNT_SATURATE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              busy,
   output logic              halted,
   output logic              err,
   output logic [ADDR_W-1:0] pc,
   output logic [CNT_W-1:0]  acc_count
);
   localparam int AB = ADDR_W / BYTE_W;
   localparam int IW = $clog2(3 * AB);

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("BYTE_W must be 8: opcodes are byte values");
      end
      if (ADDR_W % BYTE_W != 0 || ADDR_W < BYTE_W) begin : g_bad_addr
         $error("ADDR_W must be a nonzero multiple of BYTE_W");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic [2:0][ADDR_W-1:0] fields;
   logic                   fa_load;
   logic [IW-1:0]          fa_idx;
   logic [7:0]             opc_q;
   logic [BYTE_W-1:0]      op_a_q;

   tae_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mem_rdata (mem_rdata),
      .fields    (fields),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .fa_load   (fa_load),
      .fa_idx    (fa_idx),
      .opc_q     (opc_q),
      .op_a_q    (op_a_q),
      .busy      (busy),
      .halted    (halted),
      .err       (err),
      .pc        (pc)
   );

   tae_field_asm #(
      .ADDR_W   (ADDR_W),
      .BYTE_W   (BYTE_W),
      .N_FIELDS (3),
      .MSB_FIRST(ADDR_MSB_FIRST)
   ) u_fields (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (fa_load),
      .idx    (fa_idx),
      .din    (mem_rdata),
      .fields (fields)
   );

   tae_alu #(.W(BYTE_W)) u_alu (
      .opc (opc_q),
      .a   (op_a_q),
      .b   (mem_rdata),
      .y   (mem_wdata)
   );

   tae_acc_cnt #(.W(CNT_W), .SATURATE(CNT_SATURATE)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (mem_req),
      .cnt   (acc_count)
   );

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!busy && !halted && !err && !mem_req && pc == '0 && acc_count == '0));
   a_r2_busy_halt_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && halted));

endmodule

// File: tb/tb_tri_addr_exec.sv
`timescale 1ns/1ps
module tb_tri_addr_exec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        mem_req, mem_we;
   logic [23:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;
   logic        busy, halted, err;
   logic [23:0] pc;
   logic [31:0] acc_count;

   always #2 clk = ~clk;

   tri_addr_exec dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .halted(halted), .err(err), .pc(pc), .acc_count(acc_count)
   );

   // Memory model, byte array indexed by the low address byte.
   logic [7:0] mem    [256];
   logic [7:0] shadow [256];
   logic       ld_en = 1'b0;
   logic [7:0] ld_a  = '0;
   logic [7:0] ld_d  = '0;

   initial mem_rdata = '0;
   always @(posedge clk) begin
      if (ld_en) mem[ld_a] <= ld_d;
      else if (mem_req) begin
         if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[7:0]];
      end
   end

   typedef struct packed {
      logic        we;
      logic [23:0] a;
      logic [7:0]  d;
   } acc_t;
   acc_t exp_q[$];

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // Scoreboard monitor: every access is compared with the predicted one.
   always @(negedge clk) begin
      if (rst_n && mem_req) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8/R10 unexpected access", {7'd0, mem_we, mem_addr}, 32'hFFFFFFFF);
         end else begin
            acc_t e;
            e = exp_q.pop_front();
            chk(mem_we == e.we && mem_addr == e.a, "R3/R5 access address",
                {7'd0, mem_we, mem_addr}, {7'd0, e.we, e.a});
            if (e.we)
               chk(mem_wdata == e.d, "R4 write data", {24'd0, mem_wdata}, {24'd0, e.d});
         end
      end
   end

   task automatic load_byte(input logic [7:0] a, input logic [7:0] d);
      ld_en = 1'b1; ld_a = a; ld_d = d;
      shadow[a] = d;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   // Driver: places one instruction and predicts its accesses.
   task automatic put_instr(input logic [7:0] at, input logic [7:0] opc,
                            input logic [23:0] sa, input logic [23:0] sb,
                            input logic [23:0] dst);
      logic [7:0] bytes [10];
      logic [7:0] va, vb, r;
      bytes[0] = opc;
      for (int k = 0; k < 3; k++) begin
         bytes[1+k] = sa[23-8*k -: 8];
         bytes[4+k] = sb[23-8*k -: 8];
         bytes[7+k] = dst[23-8*k -: 8];
      end
      for (int k = 0; k < 10; k++) load_byte(at + 8'(k), bytes[k]);
      for (int k = 0; k < 10; k++) exp_q.push_back('{1'b0, 24'(at) + 24'(k), 8'h00});
      exp_q.push_back('{1'b0, sa, 8'h00});
      exp_q.push_back('{1'b0, sb, 8'h00});
      va = shadow[sa[7:0]];
      vb = shadow[sb[7:0]];
      case (opc)
         8'h00: r = va + vb;
         8'h01: r = va - vb;
         8'h02: r = va & vb;
         8'h03: r = va | vb;
         default: r = va ^ vb;
      endcase
      shadow[dst[7:0]] = r;
      exp_q.push_back('{1'b1, dst, r});
   endtask

   task automatic put_stop(input logic [7:0] at, input logic [7:0] opc);
      load_byte(at, opc);
      exp_q.push_back('{1'b0, 24'(at), 8'h00});
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_halt(input int limit);
      int n = 0;
      while (!halted && n < limit) begin
         @(negedge clk);
         n++;
      end
      chk(halted == 1'b1, "R8 halt reached in time", {31'd0, halted}, 32'd1);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(!busy && !halted && !err && !mem_req, "R1 reset flags",
          {28'd0, busy, halted, err, mem_req}, 32'd0);
      chk(pc == 24'd0, "R1 reset pc", {8'd0, pc}, 32'd0);
      chk(acc_count == 32'd0, "R1 reset count", acc_count, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
      @(negedge clk);
      do_reset();

      // Operand data
      load_byte(8'h80, 8'h25); load_byte(8'h81, 8'h5A);
      load_byte(8'h82, 8'h05); load_byte(8'h83, 8'h09);
      load_byte(8'h84, 8'hF0); load_byte(8'h85, 8'h3C);
      // Program 1: one of each operation, then a chained add, then stop.
      put_instr(8'd0,  8'h00, 24'h120080, 24'hAB0081, 24'h000090);
      put_instr(8'd10, 8'h01, 24'h340082, 24'h000083, 24'h560091);
      put_instr(8'd20, 8'h02, 24'h000084, 24'h000085, 24'h000092);
      put_instr(8'd30, 8'h03, 24'h000084, 24'h000085, 24'h000093);
      put_instr(8'd40, 8'h04, 24'h000084, 24'h000085, 24'h000094);
      put_instr(8'd50, 8'h00, 24'h000091, 24'h000090, 24'h000095);
      put_stop(8'd60, 8'hFF);

      chk(!busy && !mem_req, "R10 idle before start", {30'd0, busy, mem_req}, 32'd0);
      pulse_start();
      // R2: request at pc on the first cycle after start
      chk(busy && mem_req && !mem_we && mem_addr == 24'd0, "R2 launch",
          {7'd0, busy, mem_addr}, {7'd0, 1'b1, 24'd0});
      repeat (15) @(negedge clk);
      pulse_start();   // R10: pulse in mid instruction must not disturb anything
      wait_halt(200);

      chk(!busy && halted && !err, "R8 stop flags", {29'd0, busy, halted, err}, 32'd2);
      chk(pc == 24'd60, "R6/R8 pc at stop", {8'd0, pc}, 32'd60);
      chk(acc_count == 32'd79, "R7 access count", acc_count, 32'd79);
      chk(mem[8'h90] == 8'h7F, "R4 add", {24'd0, mem[8'h90]}, 32'h7F);
      chk(mem[8'h91] == 8'hFC, "R4 sub wrap", {24'd0, mem[8'h91]}, 32'hFC);
      chk(mem[8'h92] == 8'h30, "R4 and", {24'd0, mem[8'h92]}, 32'h30);
      chk(mem[8'h93] == 8'hFC, "R4 or", {24'd0, mem[8'h93]}, 32'hFC);
      chk(mem[8'h94] == 8'hCC, "R4 xor", {24'd0, mem[8'h94]}, 32'hCC);
      chk(mem[8'h95] == 8'h7B, "R11 chained result", {24'd0, mem[8'h95]}, 32'h7B);

      pulse_start();   // R10: start after halt is ignored
      repeat (6) @(negedge clk);
      chk(halted && !busy && acc_count == 32'd79, "R10 start after halt",
          acc_count, 32'd79);
      chk(exp_q.size() == 0, "R5 all predicted accesses seen", exp_q.size(), 32'd0);

      // Program 2: one xor, then an unknown opcode.
      do_reset();
      put_instr(8'd0, 8'h04, 24'h000084, 24'h000084, 24'h000096);
      put_stop(8'd10, 8'h07);
      pulse_start();
      wait_halt(100);
      chk(err && halted && !busy, "R9 error stop", {29'd0, busy, halted, err}, 32'd3);
      chk(pc == 24'd10, "R9 pc at bad opcode", {8'd0, pc}, 32'd10);
      chk(acc_count == 32'd14, "R7 count with error stop", acc_count, 32'd14);
      chk(mem[8'h96] == 8'h00, "R4 xor self", {24'd0, mem[8'h96]}, 32'h0);
      chk(exp_q.size() == 0, "R9 all predicted accesses seen", exp_q.size(), 32'd0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule